// File: doc/BRIEF.md
# Two-Frame Controlled-Slip Elastic Store

This block sits between a bit-serial writer and a bit-serial reader and absorbs the small rate differences between them. It holds two frames of 256 bits each. Every stored bit carries its frame-start marker, so a reader sees frame boundaries exactly where the writer placed them. When the writer gets ahead by a full store, a whole frame is thrown away. When the reader finds nothing to read, the last frame is played again. Both kinds of slip move the read position by exactly one frame, so frame alignment survives every slip. Each slip sets a sticky flag, and a clear strobe resets the flags.

A two-bit mode input picks one of three behaviours. The first is the slip-correcting store described above. The second is a plain FIFO in which reads trail the write position by a programmed distance. The third is a bypass that sends the input bits straight to the output, one cycle later. Both sides share one clock and use separate write and read strobes.

Top module: `es_slip_store`

## Requirements
- R1: While `rst` is high, `rd_bit`, `rd_fs`, `ovf_slip` and `unf_slip` are all 0 at the next clock edge.
- R2: The mode is decoded as follows: 2'b01 is slip mode, 2'b10 is FIFO mode, and 2'b00 and 2'b11 are both bypass.
- R3: In slip mode, a read (`rd_en`=1) drives `rd_bit`/`rd_fs` after that clock edge. The values are the oldest stored bit and the marker written with it, in write order. With `rd_en`=0 the outputs hold.
- R4: In slip mode, a write at an occupancy of 512 with no read in the same cycle discards the 256 oldest bits. The new bit is still stored, and `ovf_slip` is 1 after that edge.
- R5: In slip mode, a read at an occupancy of 0 replays the 256 positions just behind the read position, starting with the oldest. This happens whether or not a write comes in the same cycle, and `unf_slip` is 1 after that edge.
- R6: In slip mode, a read and a write in the same cycle at occupancy 512 cause no slip, and the occupancy stays at 512.
- R7: The slip flags stay set until `clr_status` is high at a clock edge. A slip in the same cycle as a clear leaves its flag set.
- R8: In bypass, `rd_bit`/`rd_fs` equal the `wr_bit`/`wr_fs` of the previous cycle, whatever the strobes are.
- R9: In FIFO mode, a read returns the bit stored `latency` writes behind the current write position (`latency` from 1 to 511). A read with no write repeats the same bit. No slip flag changes.
- R10: In any cycle where the mode differs from the mode of the previous cycle, both positions and the occupancy return to zero. The strobes are ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operating mode select |
| wr_en | input | 1 | Write strobe |
| wr_bit | input | 1 | Serial data in |
| wr_fs | input | 1 | Frame-start marker of the written bit |
| rd_en | input | 1 | Read strobe |
| latency | input | ADDR_W (9) | FIFO-mode read distance in bits |
| clr_status | input | 1 | Clears the slip flags |
| rd_bit | output | 1 | Serial data out |
| rd_fs | output | 1 | Frame-start marker of the output bit |
| ovf_slip | output | 1 | Sticky overflow-slip flag |
| unf_slip | output | 1 | Sticky underflow-slip flag |

## Verification
A read and a write can arrive in the same cycle at either occupancy limit, and then only one of the two slips is allowed. The bench fills the store to 512 and then issues a paired read and write. It checks that the overflow flag stays clear and that the next 512 reads come out in order. It then drains the store to empty and issues a paired read, write and status clear. It checks that the underflow still happens, that the flag survives the clear, and that the bit written in that cycle follows the replayed frame.

// File: rtl/es_pkg.sv
package es_pkg;

    typedef enum logic [1:0] {
        ES_PASS_LO = 2'b00,
        ES_SLIP    = 2'b01,
        ES_FIFO    = 2'b10,
        ES_PASS_HI = 2'b11
    } es_mode_e;

    typedef struct packed {
        logic fs;
        logic dat;
    } es_cell_t;

    function automatic logic es_is_bypass(es_mode_e m);
        return (m == ES_PASS_LO) || (m == ES_PASS_HI);
    endfunction

endpackage

// File: rtl/es_cell_ram.sv
module es_cell_ram
    import es_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  es_cell_t          wdata,
    input  logic [ADDR_W-1:0] raddr,
    output es_cell_t          rdata
);
    es_cell_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/es_ptr_ctrl.sv
module es_ptr_ctrl
    import es_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int ADDR_W     = $clog2(2 * FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  es_mode_e          mode,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] latency,
    output logic              wr_go,
    output logic              rd_go,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              ovf_evt,
    output logic              unf_evt
);
    localparam int DEPTH = 2 * FRAME_BITS;
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] FRAME_A = ADDR_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0]  FRAME_C = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0]  FULL_C  = CNT_W'(DEPTH);

    es_mode_e          mode_q;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr, rd_ptr_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              restart, slip_on, fifo_on;

    always_comb begin
        restart = (mode != mode_q);
        slip_on = (mode == ES_SLIP) && !restart;
        fifo_on = (mode == ES_FIFO) && !restart;
        wr_go   = (slip_on || fifo_on) && wr_en;
        rd_go   = (slip_on || fifo_on) && rd_en;
        unf_evt = slip_on && rd_en && (cnt == '0);
        ovf_evt = slip_on && wr_en && !rd_en && (cnt == FULL_C);
        wr_addr = wr_ptr;
        if (fifo_on)      rd_addr = wr_ptr - latency;
        else if (unf_evt) rd_addr = rd_ptr - FRAME_A;
        else              rd_addr = rd_ptr;

        rd_ptr_n = rd_ptr + ADDR_W'(rd_go);
        cnt_n    = cnt + CNT_W'(wr_go) - CNT_W'(rd_go);
        if (unf_evt) begin
            rd_ptr_n = rd_ptr_n - FRAME_A;
            cnt_n    = cnt_n + FRAME_C;
        end
        if (ovf_evt) begin
            rd_ptr_n = rd_ptr_n + FRAME_A;
            cnt_n    = cnt_n - FRAME_C;
        end
    end

    always_ff @(posedge clk) begin
        mode_q <= mode;
        if (rst || restart) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            wr_ptr <= wr_ptr + ADDR_W'(wr_go);
            if (slip_on) begin
                rd_ptr <= rd_ptr_n;
                cnt    <= cnt_n;
            end
        end
    end

    assert_occupancy_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_C);

    assert_full_pair_R6: assert property (@(posedge clk) disable iff (rst)
        (slip_on && cnt == FULL_C && wr_en && rd_en) |=> (cnt == FULL_C));

    assert_replay_frame_R5: assert property (@(posedge clk) disable iff (rst)
        (unf_evt && mode == $past(mode)) |=> (cnt == FRAME_C - 1 || cnt == FRAME_C || restart));

    assert_restart_clear_R10: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));
endmodule

// File: rtl/es_slip_flags.sv
module es_slip_flags (
    input  logic clk,
    input  logic rst,
    input  logic ovf_evt,
    input  logic unf_evt,
    input  logic clr,
    output logic ovf_flag,
    output logic unf_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            ovf_flag <= ovf_evt | (ovf_flag & ~clr);
            unf_flag <= unf_evt | (unf_flag & ~clr);
        end
    end

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !clr) |=> ovf_flag);

    assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (unf_flag && !clr) |=> unf_flag);

    assert_ovf_set_R4: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag);

    assert_unf_set_R5: assert property (@(posedge clk) disable iff (rst)
        unf_evt |=> unf_flag);
endmodule

// File: rtl/es_slip_store.sv
module es_slip_store
    import es_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int ADDR_W     = $clog2(2 * FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic              wr_fs,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] latency,
    input  logic              clr_status,
    output logic              rd_bit,
    output logic              rd_fs,
    output logic              ovf_slip,
    output logic              unf_slip
);
    localparam int DEPTH = 2 * FRAME_BITS;

    es_mode_e          mode_e;
    logic              byp;
    logic              wr_go, rd_go, ovf_evt, unf_evt;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    es_cell_t          wcell, rcell, out_q;

    assign mode_e = es_mode_e'(mode);
    assign byp    = es_is_bypass(mode_e);
    assign wcell  = '{fs: wr_fs, dat: wr_bit};

    es_ptr_ctrl #(.FRAME_BITS(FRAME_BITS), .ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst(rst), .mode(mode_e),
        .wr_en(wr_en), .rd_en(rd_en), .latency(latency),
        .wr_go(wr_go), .rd_go(rd_go),
        .wr_addr(wr_addr), .rd_addr(rd_addr),
        .ovf_evt(ovf_evt), .unf_evt(unf_evt)
    );

    es_cell_ram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(wr_go), .waddr(wr_addr), .wdata(wcell),
        .raddr(rd_addr), .rdata(rcell)
    );

    es_slip_flags u_flags (
        .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .unf_evt(unf_evt),
        .clr(clr_status), .ovf_flag(ovf_slip), .unf_flag(unf_slip)
    );

    always_ff @(posedge clk) begin
        if (rst)        out_q <= '0;
        else if (byp)   out_q <= wcell;
        else if (rd_go) out_q <= rcell;
    end

    assign rd_bit = out_q.dat;
    assign rd_fs  = out_q.fs;

    assert_bypass_delay_R8: assert property (@(posedge clk) disable iff (rst)
        byp |=> (rd_bit == $past(wr_bit) && rd_fs == $past(wr_fs)));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!byp && !rd_en) |=> ($stable(rd_bit) && $stable(rd_fs)));

    assert_fifo_noslip_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_e == ES_FIFO && !clr_status) |=> ($stable(ovf_slip) && $stable(unf_slip)));
endmodule

// File: tb/tb_es_slip_store.sv
module tb_es_slip_store;
    localparam int FRAME  = 256;
    localparam int DEPTH  = 2 * FRAME;
    localparam int ADDR_W = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'b01;
    logic wr_en = 0, wr_bit = 0, wr_fs = 0, rd_en = 0, clr_status = 0;
    logic [ADDR_W-1:0] latency = 9'd5;
    logic rd_bit, rd_fs, ovf_slip, unf_slip;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // items: {known, fs, bit}
    logic [2:0] exp_q[$];
    logic [2:0] store_q[$];
    logic [2:0] hist_q[$];
    logic [2:0] log_q[$];
    int   widx = 0;
    logic [1:0] cur_mode = 2'b01;
    bit   push_flag = 0;
    bit   due = 0;

    always #10 clk = ~clk;

    es_slip_store dut (
        .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en), .wr_bit(wr_bit),
        .wr_fs(wr_fs), .rd_en(rd_en), .latency(latency), .clr_status(clr_status),
        .rd_bit(rd_bit), .rd_fs(rd_fs), .ovf_slip(ovf_slip), .unf_slip(unf_slip)
    );

    function automatic bit is_byp(logic [1:0] m);
        return (m == 2'b00) || (m == 2'b11);
    endfunction

    task automatic model_reset();
        store_q.delete();
        hist_q.delete();
        log_q.delete();
        for (int i = 0; i < FRAME; i++) hist_q.push_back(3'b000);
        widx = 0;
    endtask

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, pushes expected output items
    task automatic cyc(input bit w, input bit r, input bit c = 0);
        logic       wb, fsb;
        logic [2:0] item;
        int         k;
        @(negedge clk);
        wb  = 1'($urandom_range(0, 1));
        fsb = (widx % FRAME) == 0;
        wr_en = w; rd_en = r; wr_bit = wb; wr_fs = fsb; clr_status = c;
        mode = cur_mode;
        push_flag = 0;
        if (is_byp(cur_mode)) begin
            exp_q.push_back({1'b1, fsb, wb});
            push_flag = 1;
        end else if (cur_mode == 2'b01) begin
            if (r) begin
                if (store_q.size() == 0) store_q = hist_q;
                item = store_q.pop_front();
                exp_q.push_back(item);
                push_flag = 1;
                hist_q.push_back(item);
                if (hist_q.size() > FRAME) void'(hist_q.pop_front());
            end
            if (w) begin
                if (store_q.size() == DEPTH && !r)
                    for (int i = 0; i < FRAME; i++) void'(store_q.pop_front());
                store_q.push_back({1'b1, fsb, wb});
            end
        end else begin
            if (r) begin
                k = log_q.size() - int'(latency);
                item = (k >= 0) ? log_q[k] : 3'b000;
                exp_q.push_back(item);
                push_flag = 1;
            end
            if (w) log_q.push_back({1'b1, fsb, wb});
        end
        if (w) widx++;
    endtask

    task automatic set_mode(input logic [1:0] m);
        cur_mode = m;
        model_reset();
        cyc(0, 0);
    endtask

    task automatic chk_flags(input string req, input logic eo, input logic eu);
        @(posedge clk);
        #2;
        check(req, {ovf_slip, unf_slip}, {eo, eu});
    endtask

    always @(posedge clk) due <= push_flag;

    // monitor: compares each produced output against the scoreboard head
    always @(negedge clk) begin
        logic [2:0] e;
        if (!rst && due && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            if (e[2]) check(is_byp(mode) ? "R8 bypass data" :
                            (mode == 2'b10 ? "R9 fifo data" : "R3/R5 slip data"),
                            {rd_fs, rd_bit}, e[1:0]);
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {rd_fs, rd_bit}, 2'b00);
        check("R1 reset flags", {ovf_slip, unf_slip}, 2'b00);
        rst = 0;

        // R2 mode 01 = slip: fill two frames, no slip yet
        for (int i = 0; i < DEPTH; i++) cyc(1, 0);
        chk_flags("R4 no slip at fill", 0, 0);
        cyc(1, 0);
        chk_flags("R4 overflow slip", 1, 0);
        for (int i = 0; i < FRAME - 1; i++) cyc(1, 0);
        cyc(0, 0, 1);
        chk_flags("R7 clear", 0, 0);
        cyc(1, 1);
        chk_flags("R6 paired at full", 0, 0);
        for (int i = 0; i < DEPTH; i++) cyc(0, 1);
        chk_flags("R3 drain no slip", 0, 0);
        cyc(0, 1);
        chk_flags("R5 underflow slip", 0, 1);
        for (int i = 0; i < FRAME - 1; i++) cyc(0, 1);
        cyc(0, 0, 1);
        chk_flags("R7 clear unf", 0, 0);
        cyc(1, 1, 1);
        chk_flags("R5 R7 paired at empty with clear", 0, 1);
        for (int i = 0; i < 400; i++)
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

        // R8 bypass, both codes
        set_mode(2'b00);
        for (int i = 0; i < 40; i++)
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        set_mode(2'b11);
        for (int i = 0; i < 40; i++)
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

        // R9 FIFO with short then long latency
        latency = 9'd5;
        set_mode(2'b10);
        cyc(0, 0, 1);
        for (int i = 0; i < 5; i++) cyc(1, 0);
        for (int i = 0; i < 100; i++) cyc(1, 1);
        for (int i = 0; i < 5; i++) cyc(0, 1);
        chk_flags("R9 no slip in fifo", 0, 0);
        for (int i = 0; i < 300; i++) cyc(1, 0);
        latency = 9'd300;
        for (int i = 0; i < 600; i++) cyc(1, 1);
        for (int i = 0; i < 200; i++) cyc(0, 1);
        chk_flags("R9 no slip long run", 0, 0);

        // R10 mode change empties the store
        set_mode(2'b01);
        cyc(0, 1);
        chk_flags("R10 empty after mode change", 0, 1);
        for (int i = 0; i < FRAME - 1; i++) cyc(0, 1);
        for (int i = 0; i < 20; i++) cyc(1, 0);
        for (int i = 0; i < 20; i++) cyc(0, 1);
        cyc(0, 0);
        repeat (3) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule